// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block holds the page-select value that a small microcontroller core uses to choose which bank of peripheral registers is visible, together with two saved copies underneath it. The three 8-bit levels form a hardware stack: the top level is the active page, the middle level is the next page and the bottom level is the last page. When the core enters an interrupt handler, it strobes the block with the page code of the interrupting peripheral. The stack shifts down one level and the new code lands on top, so the handler sees its own registers without any software action. The old bottom value is dropped.

When the handler returns, the stack pops and the interrupted code gets its page back. A higher-priority interrupt that preempts a running handler simply pushes again, so two levels of nesting are restored in order.

Software can write any level and can read any level through a small register port. An enable input turns automatic switching off. While it is off, interrupt entry and return leave the stack alone.

Top module: `page_stack`

## Requirements
- R1: A synchronous active-high reset clears all three levels, the read data and the page output to 0x00.
- R2: With auto_en high, an irq_enter cycle loads irq_code into the active level. The new value appears on page_o after that clock edge.
- R3: On the same push, the old active value moves to the next level and the old next value moves to the last level. Whatever the last level held, including a value written by software, is lost.
- R4: Two pushes in a row model preemption. Starting from active 0x02 and next 0x0F, a push of 0x00 leaves active 0x00, next 0x02 and last 0x0F.
- R5: With auto_en high, an irq_return cycle without irq_enter pops the stack. Active takes the old next value, next takes the old last value, and last keeps its contents. If irq_enter and irq_return are both high, the push wins.
- R6: With auto_en low, irq_enter and irq_return change none of the three levels.
- R7: A wr_en cycle writes wr_data into the level chosen by wr_addr: 0 is active, 1 is next, 2 is last. Address 3 writes nothing. A write in a cycle where a push or pop takes effect is ignored.
- R8: rd_data is registered. One clock after rd_addr is presented, rd_data shows the level that rd_addr selected as it stood before that edge: 0 is active, 1 is next, 2 is last. Address 3 reads 0x00. page_o always equals the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables automatic push and pop on interrupt entry and return |
| irq_enter | input | 1 | Interrupt entry strobe; one cycle per entry |
| irq_code | input | 8 | Page code of the interrupting peripheral, valid with irq_enter |
| irq_return | input | 1 | Interrupt return strobe; one cycle per return |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | 2 | Software write level select |
| wr_data | input | 8 | Software write data |
| rd_addr | input | 2 | Software read level select |
| rd_data | output | 8 | Registered read data |
| page_o | output | 8 | Current active page |

## Verification
The assertions treat every input as synchronous to clk. They also assume reset is held for at least one edge before the first strobe, so the $past values they compare against are defined. Neither strobe is assumed exclusive. The block resolves a simultaneous entry and return itself, and the bench drives that overlap on purpose, including with writes on the same cycle and with auto_en low. The random stimulus draws every input freely, with address 3 included, so no assumption is narrowed beyond the synchronous timing that the bench provides by driving on the falling edge.

// File: rtl/page_stack_pkg.sv
package page_stack_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_WRITE = 2'd3
  } stk_op_e;
endpackage

// File: rtl/page_stack_ctl.sv
module page_stack_ctl
  import page_stack_pkg::*;
(
  input  logic    auto_en,
  input  logic    irq_enter,
  input  logic    irq_return,
  input  logic    wr_en,
  output stk_op_e op
);
  always_comb begin
    if (auto_en && irq_enter)       op = OP_PUSH;
    else if (auto_en && irq_return) op = OP_POP;
    else if (wr_en)                 op = OP_WRITE;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/page_stack_level.sv
module page_stack_level
  import page_stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [DATA_W-1:0] from_above,
  input  logic [DATA_W-1:0] from_below,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_PUSH:  q <= from_above;
        OP_POP:   q <= from_below;
        OP_WRITE: if (wr_addr == MY_ADDR) q <= wr_data;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/page_stack_rdport.sv
module page_stack_rdport #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] lvl [DEPTH],
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr == ADDR_W'(i)) sel = lvl[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end

  // R8
  unused_addr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_addr) >= DEPTH) |=> (rd_data == '0));
endmodule

// File: rtl/page_stack.sv
module page_stack
  import page_stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic              irq_enter,
  input  logic [DATA_W-1:0] irq_code,
  input  logic              irq_return,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] page_o
);
  localparam int TOP = 0;
  localparam int BOT = DEPTH - 1;

  stk_op_e           op;
  logic [DATA_W-1:0] lvl [DEPTH];

  page_stack_ctl u_ctl (
    .auto_en   (auto_en),
    .irq_enter (irq_enter),
    .irq_return(irq_return),
    .wr_en     (wr_en),
    .op        (op)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [DATA_W-1:0] above_v;
    logic [DATA_W-1:0] below_v;
    if (g == TOP) begin : g_top
      assign above_v = irq_code;
    end else begin : g_mid
      assign above_v = lvl[g-1];
    end
    if (g == BOT) begin : g_bot
      assign below_v = lvl[g];
    end else begin : g_up
      assign below_v = lvl[g+1];
    end
    page_stack_level #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX(g)) u_level (
      .clk       (clk),
      .rst       (rst),
      .op        (op),
      .from_above(above_v),
      .from_below(below_v),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .q         (lvl[g])
    );
  end

  page_stack_rdport #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .lvl    (lvl),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  assign page_o = lvl[TOP];

  // R2
  push_loads_code_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && irq_enter) |=> (page_o == $past(irq_code)));
  // R3
  push_shifts_down_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && irq_enter) |=> (lvl[1] == $past(lvl[0]) && lvl[BOT] == $past(lvl[BOT-1])));
  // R5
  pop_shifts_up_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && irq_return && !irq_enter) |=>
      (page_o == $past(lvl[1]) && lvl[1] == $past(lvl[BOT]) && $stable(lvl[BOT])));
  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && !wr_en) |=> ($stable(lvl[0]) && $stable(lvl[1]) && $stable(lvl[BOT])));
  // R7
  unused_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!(auto_en && (irq_enter || irq_return)) && 32'(wr_addr) >= DEPTH) |=>
      ($stable(lvl[0]) && $stable(lvl[1]) && $stable(lvl[BOT])));
endmodule

// File: tb/tb_page_stack.sv
module tb_page_stack;
  logic       clk = 1'b0;
  logic       rst;
  logic       auto_en, irq_enter, irq_return, wr_en;
  logic [7:0] irq_code, wr_data;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] rd_data, page_o;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] m [3];
  logic [7:0] exp_rd;

  always #4 clk = ~clk;

  page_stack dut (
    .clk(clk), .rst(rst), .auto_en(auto_en), .irq_enter(irq_enter),
    .irq_code(irq_code), .irq_return(irq_return), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .page_o(page_o)
  );

  function automatic logic [7:0] model_read(logic [1:0] a);
    return (a == 2'd3) ? 8'h00 : m[a];
  endfunction

  function automatic string pick_tag(logic en, logic ent, logic ret, logic we, logic [1:0] wa);
    if (en && ent) return "R3";
    if (en && ret) return "R5";
    if (ent || ret) return "R6";
    if (we && wa == 2'd3) return "R7";
    if (we) return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic ent, logic [7:0] code, logic ret,
                      logic we, logic [1:0] wa, logic [7:0] wd, logic [1:0] ra,
                      string tag);
    logic [7:0] o0, o1, o2;
    auto_en = en; irq_enter = ent; irq_code = code; irq_return = ret;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    exp_rd = model_read(ra);
    o0 = m[0]; o1 = m[1]; o2 = m[2];
    if (en && ent) begin
      m[0] = code; m[1] = o0; m[2] = o1;
    end else if (en && ret) begin
      m[0] = o1; m[1] = o2;
    end else if (we && wa != 2'd3) begin
      m[wa] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " page_o"}, page_o, m[0]);
  endtask

  task automatic idle_read(logic [1:0] ra, string tag);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, ra, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; auto_en = 0; irq_enter = 0; irq_return = 0; wr_en = 0;
    irq_code = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    m[0] = 0; m[1] = 0; m[2] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 page_o", page_o, 8'h00);
    idle_read(2'd1, "R1");
    idle_read(2'd2, "R1");

    // R7 / R8: software writes and reads of every level
    step(1, 0, 8'h00, 0, 1, 2'd1, 8'h0F, 2'd0, "R7");
    step(1, 0, 8'h00, 0, 1, 2'd0, 8'h02, 2'd1, "R7");
    step(1, 0, 8'h00, 0, 1, 2'd2, 8'h55, 2'd0, "R7");
    step(1, 0, 8'h00, 0, 1, 2'd3, 8'hAA, 2'd3, "R7");
    idle_read(2'd2, "R8");

    // R4: preemption push 0x00 onto active 0x02 / next 0x0F; last 0x55 lost (R3)
    step(1, 1, 8'h00, 0, 0, 2'd0, 8'h00, 2'd0, "R4");
    idle_read(2'd0, "R4");
    idle_read(2'd1, "R4");
    idle_read(2'd2, "R4");
    if (m[0] != 8'h00 || m[1] != 8'h02 || m[2] != 8'h0F) begin
      errors++; $display("FAIL R4: got model %02h expected 00/02/0F", m[0]);
    end

    // R5: pop, last kept
    step(1, 0, 8'h00, 1, 0, 2'd0, 8'h00, 2'd2, "R5");
    idle_read(2'd2, "R5");
    // R5: enter and return together, push wins
    step(1, 1, 8'h3C, 1, 0, 2'd0, 8'h00, 2'd1, "R5");
    // R7: write during push ignored
    step(1, 1, 8'h77, 0, 1, 2'd0, 8'hEE, 2'd0, "R7");
    // R6: disabled entry/return
    step(0, 1, 8'h99, 0, 0, 2'd0, 8'h00, 2'd1, "R6");
    step(0, 0, 8'h00, 1, 0, 2'd0, 8'h00, 2'd2, "R6");
    idle_read(2'd0, "R6");
    // R2: plain push
    step(1, 1, 8'hC3, 0, 0, 2'd0, 8'h00, 2'd0, "R2");

    for (int i = 0; i < 3000; i++) begin
      logic en, ent, ret, we;
      logic [1:0] wa, ra;
      logic [7:0] code, wd;
      en = ($urandom % 4) != 0; ent = ($urandom % 4) == 0; ret = ($urandom % 4) == 0;
      we = ($urandom % 2) == 0; wa = 2'($urandom); ra = 2'($urandom);
      code = 8'($urandom); wd = 8'($urandom);
      step(en, ent, code, ret, we, wa, wd, ra, pick_tag(en, ent, ret, we, wa));
      if (($urandom % 50) == 0) begin
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m[0] = 0; m[1] = 0; m[2] = 0;
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 page_o", page_o, 8'h00);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule